// File: doc/BRIEF.md
# SPI Slave Register Access Frontend

This block lets a host microcontroller reach a bank of byte-wide control registers over a four-wire SPI link. Each transaction is a fixed 16-bit frame. The first byte carries the operation and a register address. The second byte is either write data coming in on the serial input or read data going out on the serial output. The register bank sits behind a small parallel bus made of an address, a one-cycle write strobe with write data, and a one-cycle read strobe with combinational read data.

Chip select, the serial clock and the serial input are sampled by a faster system clock. They pass through synchronizer chains, and edges are found on the synchronized copies. Writes are held back until chip select returns high after exactly sixteen bits. Frames that end early or run long never change a register. A read is launched as soon as the command byte is complete. The read strobe lets registers with read side effects, such as a FIFO data port, act exactly once per read frame. The serial clock half-period must be at least SYNC_STAGES+4 system clock cycles.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame opens when chip select falls. SDI is sampled on each SCK rising edge, MSB first: the first 8 bits form the command byte and the next 8 bits form the data byte.
- R2: In a read frame, SDO takes the next bit of the fetched value, MSB first, after each SCK falling edge of the data phase. SDO does not change at any other time.
- R3: Command bit 7 set to 1 selects write and 0 selects read. Bits 6 and 5 have no effect. Bits 4..0 are the register address presented on reg_addr.
- R4: A write frame raises reg_wr for one cycle, with reg_addr and reg_wdata valid, only after chip select has returned high. No strobe is given while chip select is still low, even after all 16 bits.
- R5: A read frame raises reg_rd once the 8th command bit has arrived, and shifts out the value on reg_rdata. The SDI bits in its data phase cause no write.
- R6: A frame cut short by chip select before the 16th bit causes no write. A frame cut before the 8th bit also causes no read strobe.
- R7: sdo_oe is low while chip select is high, so SDO is high impedance. It is high while a frame is selected.
- R8: reg_rd lasts exactly one cycle per read frame, and reg_rd and reg_wr are never high together.
- R9: A frame with more than 16 SCK rising edges commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Chip select, low active |
| spi_clk | input | 1 | Serial clock from the host |
| spi_din | input | 1 | Serial data into the block |
| spi_dout | output | 1 | Serial data out of the block |
| spi_dout_oe | output | 1 | Drive enable for spi_dout |
| reg_addr | output | ADDR_W | Register address from the command byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data from the register bank |

## Verification
The bench builds the block with its defaults: a 5-bit address, 8-bit data and two synchronizer stages. With these values all 32 addresses are reachable, so the bench writes and reads back every register with distinct values. It drives SCK with a half-period of six system clocks, which gives the margin needed for the read fetch and the first SDO update after synchronization. Frames of 5, 12, 16 and 20 bits cover early abort, the exact commit boundary and over-length rejection.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CMD_BITS = 8;
  localparam int RW_BIT   = 7;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } spi_op_e;

  // Total SCK rising edges in one well-formed frame.
  function automatic int frame_bits(input int data_w);
    return CMD_BITS + data_w;
  endfunction

  // Width of a bit counter that can count one past the frame length.
  function automatic int cnt_width(input int data_w);
    return $clog2(frame_bits(data_w) + 2);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic              rd_phase
);
  localparam int FRAME_BITS = frame_bits(DATA_W);
  localparam int CNT_W      = cnt_width(DATA_W);
  localparam logic [CNT_W-1:0] C_CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] C_CMD      = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] C_OVER     = CNT_W'(FRAME_BITS + 1);

  logic [CNT_W-1:0]    cnt;
  logic [CMD_BITS-2:0] cmd_sh;
  logic [DATA_W-1:0]   dat_sh;
  logic                wr_frame;
  logic                rd_frame;

  // Named events for the assertions below.
  logic    cmd_done;
  logic    frame_full;
  logic    commit;
  spi_op_e op_now;

  assign op_now     = spi_op_e'(cmd_sh[RW_BIT-1]);
  assign cmd_done   = sck_rise && (cnt == C_CMD_LAST);
  assign frame_full = (cnt == C_FULL);
  assign commit     = cs_rise && frame_full && wr_frame;
  assign rd_phase   = rd_frame && (cnt >= C_CMD) && (cnt < C_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cmd_sh    <= '0;
      dat_sh    <= '0;
      wr_frame  <= 1'b0;
      rd_frame  <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (cs_n_s) begin
        cnt      <= '0;
        cmd_sh   <= '0;
        dat_sh   <= '0;
        wr_frame <= 1'b0;
        rd_frame <= 1'b0;
        if (commit) begin
          reg_wr    <= 1'b1;
          reg_wdata <= dat_sh;
        end
      end else if (sck_rise) begin
        if (cnt != C_OVER) cnt <= cnt + 1'b1;
        if (cnt < C_CMD)       cmd_sh <= {cmd_sh[CMD_BITS-3:0], sdi_s};
        else if (cnt < C_FULL) dat_sh <= {dat_sh[DATA_W-2:0], sdi_s};
        if (cmd_done) begin
          reg_addr <= {cmd_sh[ADDR_W-2:0], sdi_s};
          if (op_now == OP_WRITE) begin
            wr_frame <= 1'b1;
          end else begin
            rd_frame <= 1'b1;
            reg_rd   <= 1'b1;
          end
        end
      end
    end
  end

  // R4: a write strobe follows a release of chip select after a full frame.
  assert_wr_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (cs_n_s && $past(frame_full) && $past(cs_rise)));

  // R6: a release at any other count never yields a write strobe.
  assert_short_no_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !frame_full) |=> !reg_wr);

  // R5: the read strobe comes right after the last command bit.
  assert_rd_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (cnt == C_CMD && rd_frame && !wr_frame));

  // R8: a read strobe lasts a single cycle.
  assert_rd_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R9: the bit counter never passes its saturation value.
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= C_OVER);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic              sdo
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (clr) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (load) begin
      sh <= load_data;
    end else if (shift_en) begin
      sdo <= sh[DATA_W-1];
      sh  <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  // R2: the output bit moves only after a data-phase falling edge or a clear.
  assert_sdo_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(shift_en) && !$past(clr)) |-> $stable(sdo));
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sel_n,
  input  logic              spi_clk,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              spi_dout_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0] pins_s;
  logic       cs_n_s, sck_s, sdi_s;
  logic       cs_n_d, sck_d;
  logic       cs_rise, sck_rise, sck_fall;
  logic       rd_phase;

  spi_in_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sel_n, spi_clk, spi_din}),
    .dout (pins_s)
  );

  assign {cs_n_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d      <= 1'b1;
      sck_d       <= 1'b0;
      spi_dout_oe <= 1'b0;
    end else begin
      cs_n_d      <= cs_n_s;
      sck_d       <= sck_s;
      spi_dout_oe <= !cs_n_s;
    end
  end

  assign cs_rise  = cs_n_s && !cs_n_d;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  spi_frame_ctl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sdi_s    (sdi_s),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rd   (reg_rd),
    .rd_phase (rd_phase)
  );

  spi_tx_shift #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_n_s),
    .load     (reg_rd),
    .load_data(reg_rdata),
    .shift_en (sck_fall && rd_phase && !cs_n_s),
    .sdo      (spi_dout)
  );

  // R7: no drive while chip select has been high for two cycles.
  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !spi_dout_oe);

  // R8: the two bus strobes never coincide.
  assert_wr_rd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/spi_reg_bridge_tb.sv
module spi_reg_bridge_tb;
  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe;
  logic [4:0] addr;
  logic       wr, rd;
  logic [7:0] wdata, rdata;

  logic [7:0] bank [32];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  int         checks = 0;
  int         errors = 0;
  int         wr_before_release = 0;
  logic       oe_in_frame = 1'b0;

  always #5 clk = ~clk;

  spi_reg_bridge u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sel_n  (sel_n),
    .spi_clk    (sck),
    .spi_din    (sdi),
    .spi_dout   (sdo),
    .spi_dout_oe(sdo_oe),
    .reg_addr   (addr),
    .reg_wr     (wr),
    .reg_wdata  (wdata),
    .reg_rd     (rd),
    .reg_rdata  (rdata)
  );

  assign rdata = bank[addr];

  always @(posedge clk) begin
    if (wr) begin
      bank[addr] <= wdata;
      wr_cnt     <= wr_cnt + 1;
    end
    if (rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One frame of nbits SCK cycles; extra bits past 16 are ones.
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] din, input int nbits,
                      output logic [7:0] dout);
    logic [15:0] word;
    word = {cmd, din};
    dout = '0;
    @(negedge clk);
    sel_n = 1'b0;
    sck   = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b1;
      repeat (HP) @(negedge clk);
      if (i >= 8 && i < 16) dout = {dout[6:0], sdo};
      if (i == 2) oe_in_frame = sdo_oe;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2 * HP) @(negedge clk);
    wr_before_release = wr_cnt;
    sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sdo_oe == 1'b0, "R7 reset oe", sdo_oe, 0);
    chk(wr == 1'b0 && rd == 1'b0, "R8 reset strobes", {wr, rd}, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    int w0, r0;
    w0 = wr_cnt;
    xfer(8'h85, 8'hA5, 16, d);
    chk(wr_before_release == w0, "R4 no write before release", wr_before_release, w0);
    chk(wr_cnt == w0 + 1, "R4 one write", wr_cnt, w0 + 1);
    chk(bank[5] == 8'hA5, "R1 write data", bank[5], 8'hA5);
    chk(oe_in_frame == 1'b1, "R7 oe in frame", oe_in_frame, 1);
    chk(sdo_oe == 1'b0, "R7 oe idle", sdo_oe, 0);
    r0 = rd_cnt;
    w0 = wr_cnt;
    xfer(8'h05, 8'hFF, 16, d);
    chk(d == 8'hA5, "R5 read value", d, 8'hA5);
    chk(rd_cnt == r0 + 1, "R8 single read strobe", rd_cnt, r0 + 1);
    chk(wr_cnt == w0 && bank[5] == 8'hA5, "R5 SDI ignored in read", bank[5], 8'hA5);
  endtask

  task automatic t_ignored_bits;
    logic [7:0] d;
    xfer(8'hE3, 8'h3C, 16, d);
    chk(bank[3] == 8'h3C, "R3 bits 6,5 ignored on write", bank[3], 8'h3C);
    xfer(8'h63, 8'h00, 16, d);
    chk(d == 8'h3C, "R3 bits 6,5 ignored on read", d, 8'h3C);
    xfer(8'h03, 8'h00, 16, d);
    chk(d == 8'h3C, "R2 read msb first", d, 8'h3C);
  endtask

  task automatic t_short;
    logic [7:0] d;
    int w0, r0;
    w0 = wr_cnt;
    xfer(8'h85, 8'h11, 12, d);
    chk(wr_cnt == w0 && bank[5] == 8'hA5, "R6 short write discarded", bank[5], 8'hA5);
    xfer(8'h85, 8'h11, 15, d);
    chk(wr_cnt == w0, "R6 fifteen bits discarded", wr_cnt, w0);
    r0 = rd_cnt;
    xfer(8'h05, 8'h00, 5, d);
    chk(rd_cnt == r0, "R6 short command no read", rd_cnt, r0);
  endtask

  task automatic t_long;
    logic [7:0] d;
    int w0;
    w0 = wr_cnt;
    xfer(8'h85, 8'h22, 20, d);
    chk(wr_cnt == w0 && bank[5] == 8'hA5, "R9 long frame no commit", bank[5], 8'hA5);
    xfer(8'h85, 8'h22, 17, d);
    chk(wr_cnt == w0, "R9 seventeen bits no commit", wr_cnt, w0);
  endtask

  task automatic t_sweep;
    logic [7:0] d;
    int bad;
    bad = 0;
    for (int a = 0; a < 32; a++) xfer({3'b100, 5'(a)}, 8'(a * 37 + 11), 16, d);
    for (int a = 0; a < 32; a++) begin
      xfer({3'b000, 5'(a)}, 8'h00, 16, d);
      if (d != 8'(a * 37 + 11)) bad++;
    end
    chk(bad == 0, "R3 all addresses round trip", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) bank[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_read();
    t_ignored_bits();
    t_short();
    t_long();
    t_sweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule